// File: doc/BRIEF.md
# Bit-Select XOR-Fold Row Index Generator

This block turns a 32-bit IPv4 address, or a prefix whose wildcard bits the caller has already resolved to concrete values, into row indexes for a multi-table hash forwarding engine. It gathers `SEL_W` key bits from positions fixed by a parameter array. The lower `IDX_W` of those gathered bits form a base segment. The remaining `SEL_W - IDX_W` gathered bits form a fold segment. The fold segment is zero-extended and rotated by a per-table skew, then XORed into the base segment. This produces one `IDX_W`-bit row index for each of `NUM_TBL` tables.

The key bits that are not gathered make up the tag. The tag also carries the fold segment. Together, any one table's index and the tag determine the key exactly, so the tag is what a row stores for comparison. The same block serves a lookup, which probes all tables at once, and an insertion, which tries the tables in turn. The choice of positions only changes which wires are routed. It never changes the timing. A parameter selects a registered output or a purely combinational one.

Top module: `addr_hash_gen`

## Requirements
- R1: Gathered vector bit i equals key bit `SEL_POS[i]`. Position i occupies bits `[5i+4:5i]` of `SEL_POS`. The default gathered positions, from i=0 upward, are 16..23, 8..11, then 24..27.
- R2: The index for table t is `g[IDX_W-1:0] XOR rotl(zext(g[SEL_W-1:IDX_W]), SKEW_t)`, where g is the gathered vector. The rotation is a left rotation within `IDX_W` bits. `SKEW_t` is bits `[8t+7:8t]` of `SKEW` (defaults 1, 4, 7). Table t appears on `idx[IDX_W*t +: IDX_W]`.
- R3: `tag[SEL_W-IDX_W-1:0]` holds the fold segment `g[SEL_W-1:IDX_W]`. The bits above it hold the non-gathered key bits in ascending key position, with the lowest such position at bit `SEL_W-IDX_W`.
- R4: With `OUT_REG=1`, `idx` and `tag` show the results for the key presented with `key_valid` high on the preceding clock edge, and `idx_valid` equals `key_valid` from that edge.
- R5: With `OUT_REG=1`, an edge with `key_valid` low leaves `idx` and `tag` unchanged whatever `key` carries, and drops `idx_valid`.
- R6: While `rst_n` is low, `idx_valid`, `idx` and `tag` are zero, without waiting for a clock edge.
- R7: With `OUT_REG=0`, `idx`, `tag` and `idx_valid` follow `key` and `key_valid` within the same cycle.
- R8: A key whose only set bit lies in the fold segment gives three pairwise different indexes under the default skews.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | Key present this cycle |
| key | input | 32 | Address or resolved prefix |
| idx_valid | output | 1 | Indexes and tag valid |
| idx | output | NUM_TBL*IDX_W | Row index per table, table 0 lowest |
| tag | output | 32-IDX_W | Non-gathered key bits above the fold segment |

## Verification
The only internal state is the output register. A wrong capture or a wrong hold shows at the ports on the first edge afterwards, as an index or tag that differs from the values computed for the key. A misrouted select wire or a wrong skew has no state to hide in. It appears on the same cycle as a single wrong bit when one key bit is walked across the word. A round trip that rebuilds the key from one index and the tag, together with the pairwise index relation, exposes any disagreement between the index path and the tag path one edge after the key is presented.

// File: rtl/ahg_pkg.sv
package ahg_pkg;
  localparam int KEY_W  = 32;
  localparam int POS_W  = 5;
  localparam int SKEW_W = 8;

  typedef logic [KEY_W-1:0] key_t;

  // Mark every key bit that appears in a packed list of n positions.
  function automatic logic [KEY_W-1:0] pos_mask(int n, logic [KEY_W*POS_W-1:0] pos);
    logic [KEY_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) begin
      m[pos[i*POS_W +: POS_W]] = 1'b1;
    end
    return m;
  endfunction

  // Packed list of the key positions left out of the mask, ascending.
  function automatic logic [KEY_W*POS_W-1:0] free_list(logic [KEY_W-1:0] mask);
    logic [KEY_W*POS_W-1:0] lst;
    int j;
    lst = '0;
    j   = 0;
    for (int p = 0; p < KEY_W; p++) begin
      if (!mask[p]) begin
        lst[j*POS_W +: POS_W] = POS_W'(p);
        j++;
      end
    end
    return lst;
  endfunction
endpackage

// File: rtl/ahg_bit_select.sv
module ahg_bit_select
  import ahg_pkg::*;
#(
  parameter int                     SEL_W   = 16,
  parameter logic [SEL_W*POS_W-1:0] SEL_POS = '0
) (
  input  key_t                    key_i,
  output logic [SEL_W-1:0]        sel_o,
  output logic [KEY_W-SEL_W-1:0]  rest_o
);
  localparam int REST_W = KEY_W - SEL_W;
  localparam logic [KEY_W-1:0]       USED_MASK = pos_mask(SEL_W, (KEY_W*POS_W)'(SEL_POS));
  localparam logic [KEY_W*POS_W-1:0] REST_POS  = free_list(USED_MASK);

  // Gathered bits: pure routing, so the positions never touch timing.
  for (genvar i = 0; i < SEL_W; i++) begin : g_sel
    assign sel_o[i] = key_i[SEL_POS[i*POS_W +: POS_W]];
  end

  // Leftover bits, ascending in key position.
  for (genvar j = 0; j < REST_W; j++) begin : g_rest
    assign rest_o[j] = key_i[REST_POS[j*POS_W +: POS_W]];
  end
endmodule

// File: rtl/ahg_xor_fold.sv
module ahg_xor_fold #(
  parameter int SEL_W = 16,
  parameter int IDX_W = 10,
  parameter int SKEW  = 1
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int FOLD_W = SEL_W - IDX_W;
  localparam int SH     = SKEW % IDX_W;

  logic [IDX_W-1:0] seg_hi;
  logic [IDX_W-1:0] seg_rot;

  // Fold segment, zero-extended to the index width.
  assign seg_hi = IDX_W'(sel_i[SEL_W-1:IDX_W]);

  // Constant left rotation by the table's skew.
  for (genvar b = 0; b < IDX_W; b++) begin : g_rot
    assign seg_rot[(b + SH) % IDX_W] = seg_hi[b];
  end

  assign idx_o = sel_i[IDX_W-1:0] ^ seg_rot;
endmodule

// File: rtl/ahg_out_stage.sv
module ahg_out_stage #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] data_i,
  output logic         vld_o,
  output logic [W-1:0] data_o
);
  if (OUT_REG) begin : g_reg
    logic         vld_d, vld_q;
    logic [W-1:0] data_d, data_q;
    logic         data_en;

    always_comb begin
      vld_d   = vld_i;
      data_en = vld_i;
      data_d  = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        data_q <= '0;
      end else begin
        vld_q <= vld_d;
        if (data_en) begin
          data_q <= data_d;
        end
      end
    end

    assign vld_o  = vld_q;
    assign data_o = data_q;
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = &{1'b0, clk, rst_n};
    assign vld_o  = vld_i;
    assign data_o = data_i;
  end
endmodule

// File: rtl/addr_hash_gen.sv
module addr_hash_gen
  import ahg_pkg::*;
#(
  parameter int                        SEL_W   = 16,
  parameter int                        IDX_W   = 10,
  parameter int                        NUM_TBL = 3,
  parameter logic [SEL_W*POS_W-1:0]    SEL_POS = {5'd27, 5'd26, 5'd25, 5'd24,
                                                  5'd11, 5'd10, 5'd9,  5'd8,
                                                  5'd23, 5'd22, 5'd21, 5'd20,
                                                  5'd19, 5'd18, 5'd17, 5'd16},
  parameter logic [NUM_TBL*SKEW_W-1:0] SKEW    = {8'd7, 8'd4, 8'd1},
  parameter bit                        OUT_REG = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     key_valid,
  input  logic [KEY_W-1:0]         key,
  output logic                     idx_valid,
  output logic [NUM_TBL*IDX_W-1:0] idx,
  output logic [KEY_W-IDX_W-1:0]   tag
);
  localparam int FOLD_W = SEL_W - IDX_W;
  localparam int REST_W = KEY_W - SEL_W;
  localparam int TAG_W  = KEY_W - IDX_W;
  localparam int OUT_W  = NUM_TBL*IDX_W + TAG_W;

  logic [SEL_W-1:0]         sel;
  logic [REST_W-1:0]        rest;
  logic [NUM_TBL*IDX_W-1:0] idx_c;
  logic [TAG_W-1:0]         tag_c;
  logic [OUT_W-1:0]         out_q;

  ahg_bit_select #(
    .SEL_W   (SEL_W),
    .SEL_POS (SEL_POS)
  ) u_sel (
    .key_i  (key),
    .sel_o  (sel),
    .rest_o (rest)
  );

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    ahg_xor_fold #(
      .SEL_W (SEL_W),
      .IDX_W (IDX_W),
      .SKEW  (int'(SKEW[t*SKEW_W +: SKEW_W]))
    ) u_fold (
      .sel_i (sel),
      .idx_o (idx_c[t*IDX_W +: IDX_W])
    );
  end

  assign tag_c = {rest, sel[SEL_W-1:SEL_W-FOLD_W]};

  ahg_out_stage #(
    .W       (OUT_W),
    .OUT_REG (OUT_REG)
  ) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (key_valid),
    .data_i ({tag_c, idx_c}),
    .vld_o  (idx_valid),
    .data_o (out_q)
  );

  assign idx = out_q[NUM_TBL*IDX_W-1:0];
  assign tag = out_q[OUT_W-1:NUM_TBL*IDX_W];
endmodule

// File: rtl/ahg_checker.sv
module ahg_checker
  import ahg_pkg::*;
#(
  parameter int                        SEL_W   = 16,
  parameter int                        IDX_W   = 10,
  parameter int                        NUM_TBL = 3,
  parameter logic [SEL_W*POS_W-1:0]    SEL_POS = '0,
  parameter logic [NUM_TBL*SKEW_W-1:0] SKEW    = '0,
  parameter bit                        OUT_REG = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     key_valid,
  input logic [KEY_W-1:0]         key,
  input logic                     idx_valid,
  input logic [NUM_TBL*IDX_W-1:0] idx,
  input logic [KEY_W-IDX_W-1:0]   tag
);
  localparam int FOLD_W = SEL_W - IDX_W;
  localparam int TAG_W  = KEY_W - IDX_W;

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  function automatic logic [IDX_W-1:0] rotl(logic [IDX_W-1:0] v, int sh);
    logic [IDX_W-1:0] r;
    for (int b = 0; b < IDX_W; b++) r[(b + sh) % IDX_W] = v[b];
    return r;
  endfunction

  function automatic int skew_of(int t);
    return int'(SKEW[t*SKEW_W +: SKEW_W]) % IDX_W;
  endfunction

  // Recover the key from table 0's index and the tag.
  function automatic logic [KEY_W-1:0] rebuild(logic [IDX_W-1:0] i0, logic [TAG_W-1:0] tg);
    logic [FOLD_W-1:0] hi;
    logic [IDX_W-1:0]  lo;
    logic [SEL_W-1:0]  g;
    logic [KEY_W-1:0]  k, used;
    int j;
    hi   = tg[FOLD_W-1:0];
    lo   = i0 ^ rotl(IDX_W'(hi), skew_of(0));
    g    = {hi, lo};
    k    = '0;
    used = '0;
    for (int i = 0; i < SEL_W; i++) begin
      k[SEL_POS[i*POS_W +: POS_W]]    = g[i];
      used[SEL_POS[i*POS_W +: POS_W]] = 1'b1;
    end
    j = 0;
    for (int p = 0; p < KEY_W; p++) begin
      if (!used[p]) begin
        k[p] = tg[FOLD_W + j];
        j++;
      end
    end
    return k;
  endfunction

  for (genvar t = 1; t < NUM_TBL; t++) begin : g_pair
    // R2
    idx_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((idx[t*IDX_W +: IDX_W] ^ idx[IDX_W-1:0]) ==
                 (rotl(IDX_W'(tag[FOLD_W-1:0]), skew_of(t)) ^
                  rotl(IDX_W'(tag[FOLD_W-1:0]), skew_of(0)))));
  end

  if (OUT_REG) begin : g_reg_chk
    // R4
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (idx_valid == $past(key_valid)));
    // R3
    key_round_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(key_valid)) |-> (rebuild(idx[IDX_W-1:0], tag) == $past(key)));
    // R5
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(key_valid)) |-> ($stable(idx) && $stable(tag)));
  end else begin : g_comb_chk
    // R7
    valid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (idx_valid == key_valid));
    // R3
    key_round_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (rebuild(idx[IDX_W-1:0], tag) == key));
  end
endmodule

bind addr_hash_gen ahg_checker #(
  .SEL_W   (SEL_W),
  .IDX_W   (IDX_W),
  .NUM_TBL (NUM_TBL),
  .SEL_POS (SEL_POS),
  .SKEW    (SKEW),
  .OUT_REG (OUT_REG)
) u_ahg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .key_valid (key_valid),
  .key       (key),
  .idx_valid (idx_valid),
  .idx       (idx),
  .tag       (tag)
);

// File: tb/addr_hash_gen_bench.sv
module addr_hash_gen_bench;
  import ahg_pkg::*;

  localparam int SW = 16;
  localparam int IW = 10;
  localparam int NT = 3;
  localparam int FW = SW - IW;
  localparam int TW = KEY_W - IW;
  localparam int POS [SW] = '{16, 17, 18, 19, 20, 21, 22, 23, 8, 9, 10, 11, 24, 25, 26, 27};
  localparam int SKV [NT] = '{1, 4, 7};

  function automatic logic [SW*POS_W-1:0] pack_pos();
    logic [SW*POS_W-1:0] r;
    for (int i = 0; i < SW; i++) r[i*POS_W +: POS_W] = POS_W'(POS[i]);
    return r;
  endfunction

  function automatic logic [NT*SKEW_W-1:0] pack_skew();
    logic [NT*SKEW_W-1:0] r;
    for (int t = 0; t < NT; t++) r[t*SKEW_W +: SKEW_W] = SKEW_W'(SKV[t]);
    return r;
  endfunction

  localparam logic [SW*POS_W-1:0]  SEL_CFG  = pack_pos();
  localparam logic [NT*SKEW_W-1:0] SKEW_CFG = pack_skew();

  logic              clk;
  logic              rst_n;
  logic              key_valid;
  logic [KEY_W-1:0]  key;
  logic              r_vld, c_vld;
  logic [NT*IW-1:0]  r_idx, c_idx;
  logic [TW-1:0]     r_tag, c_tag;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  logic [NT*IW-1:0] prev_idx;
  logic [TW-1:0]    prev_tag;

  addr_hash_gen #(
    .SEL_W(SW), .IDX_W(IW), .NUM_TBL(NT), .SEL_POS(SEL_CFG), .SKEW(SKEW_CFG), .OUT_REG(1'b1)
  ) u_addr_hash_gen (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key(key),
    .idx_valid(r_vld), .idx(r_idx), .tag(r_tag)
  );

  addr_hash_gen #(
    .SEL_W(SW), .IDX_W(IW), .NUM_TBL(NT), .SEL_POS(SEL_CFG), .SKEW(SKEW_CFG), .OUT_REG(1'b0)
  ) u_addr_hash_gen_comb (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key(key),
    .idx_valid(c_vld), .idx(c_idx), .tag(c_tag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [SW-1:0] gather(logic [KEY_W-1:0] k);
    logic [SW-1:0] g;
    for (int i = 0; i < SW; i++) g[i] = k[POS[i]];
    return g;
  endfunction

  function automatic logic [NT*IW-1:0] exp_idx(logic [KEY_W-1:0] k);
    logic [SW-1:0]    g;
    logic [IW-1:0]    hi, rot;
    logic [NT*IW-1:0] r;
    g  = gather(k);
    hi = IW'(g[SW-1:IW]);
    for (int t = 0; t < NT; t++) begin
      for (int b = 0; b < IW; b++) rot[(b + SKV[t]) % IW] = hi[b];
      r[t*IW +: IW] = g[IW-1:0] ^ rot;
    end
    return r;
  endfunction

  function automatic logic [TW-1:0] exp_tag(logic [KEY_W-1:0] k);
    logic [SW-1:0] g;
    logic [TW-1:0] tg;
    int j;
    bit hit;
    g  = gather(k);
    tg = '0;
    tg[FW-1:0] = g[SW-1:IW];
    j = 0;
    for (int p = 0; p < KEY_W; p++) begin
      hit = 1'b0;
      for (int i = 0; i < SW; i++) if (POS[i] == p) hit = 1'b1;
      if (!hit) begin
        tg[FW + j] = k[p];
        j++;
      end
    end
    return tg;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [KEY_W-1:0] k, bit v);
    logic [NT*IW-1:0] ei;
    logic [TW-1:0]    et;
    @(negedge clk);
    key       = k;
    key_valid = v;
    ei = exp_idx(k);
    et = exp_tag(k);
    #1;
    // R1 R2 R3 R7: combinational variant, same cycle
    check("R1 R2 comb idx", 64'(c_idx), 64'(ei));
    check("R3 comb tag", 64'(c_tag), 64'(et));
    check("R7 comb valid", 64'(c_vld), 64'(v));
    @(posedge clk);
    #1;
    if (v) begin
      check("R4 reg idx", 64'(r_idx), 64'(ei));
      check("R4 reg tag", 64'(r_tag), 64'(et));
      check("R4 reg valid", 64'(r_vld), 64'd1);
      prev_idx = ei;
      prev_tag = et;
    end else begin
      check("R5 hold idx", 64'(r_idx), 64'(prev_idx));
      check("R5 hold tag", 64'(r_tag), 64'(prev_tag));
      check("R5 valid low", 64'(r_vld), 64'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [KEY_W-1:0] lf;
    rst_n     = 1'b0;
    key_valid = 1'b0;
    key       = '0;
    prev_idx  = '0;
    prev_tag  = '0;
    repeat (3) @(posedge clk);
    #1;
    // R6: reset state
    check("R6 reset valid", 64'(r_vld), 64'd0);
    check("R6 reset idx", 64'(r_idx), 64'd0);
    check("R6 reset tag", 64'(r_tag), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R3: walking one and walking zero over every key bit
    for (int b = 0; b < KEY_W; b++) apply(KEY_W'(1) << b, 1'b1);
    for (int b = 0; b < KEY_W; b++) apply(~(KEY_W'(1) << b), 1'b1);
    apply('0, 1'b1);
    apply('1, 1'b1);

    // R5: idle cycles with a changing key
    apply(32'hA5A5_5A5A, 1'b0);
    apply(32'h0F0F_F0F0, 1'b0);

    // R2 R4 R5: pseudo-random keys, every fifth one idle
    lf = 32'h1234_5678;
    for (int n = 0; n < 150; n++) begin
      lf = {lf[30:0], 1'b0} ^ (lf[31] ? 32'h04C1_1DB7 : 32'h0);
      apply(lf, (n % 5) != 4);
    end

    // R8: a single fold-segment bit gives three different indexes
    for (int i = IW; i < SW; i++) begin
      apply(KEY_W'(1) << POS[i], 1'b1);
      check("R8 distinct rows",
            64'((r_idx[0 +: IW] != r_idx[IW +: IW]) &&
                (r_idx[IW +: IW] != r_idx[2*IW +: IW]) &&
                (r_idx[0 +: IW] != r_idx[2*IW +: IW])), 64'd1);
    end

    // R6: reset clears outputs without a clock edge
    apply(32'hFFFF_FFFF, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R6 async valid", 64'(r_vld), 64'd0);
    check("R6 async idx", 64'(r_idx), 64'd0);
    check("R6 async tag", 64'(r_tag), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule